// File: doc/BRIEF.md
# Four-Word Burst Sequencer for a Split-Port Synchronous SRAM

This block sequences a small synchronous memory that has a read port and a write port which work independently, and a fixed burst of four words. On every rising clock edge it samples an active-low read request, an active-low write request and one shared external base address. Each port has its own state machine. A machine that accepts a request appends two low-order bits to the base address. It then covers the four words over two clock cycles, presenting an even word and an odd word in each cycle. Only one burst may begin on a given edge, and the read port has priority. A write request that loses on that edge is discarded. It is not stored for later.

Data moves as two words per beat. Each port has a strobe: `rd_valid` marks a read beat and `wr_ready` marks a write beat. There is no back-pressure on either side. The sink must take read data in the cycle `rd_valid` is high. The source must present both write words in the cycle `wr_ready` is high, and they are stored at the edge that ends that cycle. A new request is needed to produce further beats.

Top module: `qb4_sram_seq`

## Requirements
- R1: While `rst` is high, and after it with both requests high, `rd_valid` and `wr_ready` stay low.
- R2: A request sampled low while its port is idle loads `ext_addr`. The first beat is presented in the next cycle.
- R3: A burst lasts exactly two beat cycles. The first beat carries the word offsets 0 and 1 and the second beat carries offsets 2 and 3.
- R4: The word address is `{ext_addr, offset[1:0]}`. The even output carries the even offset and the odd output carries that offset plus one. The order never wraps, including at the top base address.
- R5: A request sampled low on the edge that ends a second beat starts the next burst with no idle cycle. If the request is high on that edge, the port goes idle.
- R6: Requests and `ext_addr` sampled while a port is in its first beat are ignored by that port.
- R7: The read and write bursts can overlap in time. While both ports are active they never address words with the same offset.
- R8: If both ports could start on the same edge and both requests are low, only the read starts and the write request is dropped.
- R9: Write data present in a `wr_ready` cycle is stored at the two addressed words. A later read beat of those words returns that data combinationally, in its own `rd_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read request |
| wr_sel_n | input | 1 | Active-low write request |
| ext_addr | input | ADDR_W | Shared burst base address |
| wr_data_even | input | DATA_W | Write data for the even word of the beat |
| wr_data_odd | input | DATA_W | Write data for the odd word of the beat |
| wr_ready | output | 1 | Write beat: write data is taken this cycle |
| wr_addr_even | output | ADDR_W+2 | Even word address of the write beat |
| wr_addr_odd | output | ADDR_W+2 | Odd word address of the write beat |
| rd_valid | output | 1 | Read beat: read data valid this cycle |
| rd_addr_even | output | ADDR_W+2 | Even word address of the read beat |
| rd_addr_odd | output | ADDR_W+2 | Odd word address of the read beat |
| rd_data_even | output | DATA_W | Data of the even read word |
| rd_data_odd | output | DATA_W | Data of the odd read word |

## Verification
A request driven before edge N gives its first beat in the cycle after N and its second beat in the cycle after N+1. The bench drives inputs just after the falling edge and samples just after that. Each sample therefore sees the beat from the previous rising edge together with the write data of the current cycle. A driver task puts the two expected beats into a port's queue at the moment it issues a request. The monitor removes one entry per strobe, so beats that arrive early, late, extra or missing all show up as mismatches. Expected read data comes from a shadow memory. The shadow is updated only after the read comparison of the same cycle, because a write takes effect at the edge that ends its beat.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  localparam int unsigned BURST_WORDS   = 4;
  localparam int unsigned WORDS_PER_CLK = 2;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_BURST = 1'b1
  } phase_e;
endpackage

// File: rtl/qb4_burst_fsm.sv
module qb4_burst_fsm
  import qb4_pkg::*;
#(
  parameter  int ADDR_W  = 6,
  localparam int LOW_W   = $clog2(BURST_WORDS),
  localparam int WADDR_W = ADDR_W + LOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n,
  input  logic               hold_off,
  input  logic [ADDR_W-1:0]  base_in,
  output logic               start,
  output logic               active,
  output logic               init,
  output logic [WADDR_W-1:0] word_even,
  output logic [WADDR_W-1:0] word_odd
);
  localparam int CNT_W = LOW_W + 1;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(WORDS_PER_CLK);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_WORDS - WORDS_PER_CLK);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              init_q;
  logic              at_last;
  logic [LOW_W-1:0]  offset;

  assign at_last = (phase_q == PH_BURST) && (cnt_q == LAST);
  assign start   = !sel_n && !hold_off && ((phase_q == PH_IDLE) || at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      init_q  <= 1'b0;
    end else if (start) begin
      phase_q <= PH_BURST;
      cnt_q   <= '0;
      base_q  <= base_in;
      init_q  <= 1'b1;
    end else begin
      init_q <= 1'b0;
      if (phase_q == PH_BURST) begin
        cnt_q <= cnt_q + STEP;
        if (at_last) phase_q <= PH_IDLE;
      end
    end
  end

  assign active    = (phase_q == PH_BURST);
  assign init      = init_q;
  assign offset    = cnt_q[LOW_W-1:0];
  assign word_even = {base_q, offset};
  assign word_odd  = {base_q, offset | LOW_W'(1)};

  // R1: reset leaves the machine idle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !active);
  // R2: a start loads the count and raises the first-beat flag
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> active && init && (cnt_q == '0));
  p_init_once_r2: assert property (@(posedge clk) disable iff (rst)
    init |=> !init);
  // R3/R6: the first beat always advances by two with the base held
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (active && !at_last) |=> active && (cnt_q == $past(cnt_q) + STEP) && $stable(base_q));
  // R5: without a new request the last beat returns to idle
  p_end_r5: assert property (@(posedge clk) disable iff (rst)
    (at_last && !start) |=> !active);
endmodule

// File: rtl/qb4_word_array.sv
module qb4_word_array #(
  parameter int WADDR_W = 8,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [WADDR_W-1:0] wa_even,
  input  logic [WADDR_W-1:0] wa_odd,
  input  logic [DATA_W-1:0]  wd_even,
  input  logic [DATA_W-1:0]  wd_odd,
  input  logic [WADDR_W-1:0] ra_even,
  input  logic [WADDR_W-1:0] ra_odd,
  output logic [DATA_W-1:0]  rd_even,
  output logic [DATA_W-1:0]  rd_odd
);
  localparam int ROW_W = WADDR_W - 1;
  localparam int ROWS  = 1 << ROW_W;

  logic [1:0][DATA_W-1:0] rdat;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [ROW_W-1:0]  wrow;
    logic [ROW_W-1:0]  rrow;
    logic [DATA_W-1:0] wdat;

    assign wrow = (b == 0) ? wa_even[WADDR_W-1:1] : wa_odd[WADDR_W-1:1];
    assign rrow = (b == 0) ? ra_even[WADDR_W-1:1] : ra_odd[WADDR_W-1:1];
    assign wdat = (b == 0) ? wd_even : wd_odd;

    always_ff @(posedge clk) begin
      if (we) mem[wrow] <= wdat;
    end

    assign rdat[b] = mem[rrow];
  end

  assign rd_even = rdat[0];
  assign rd_odd  = rdat[1];

  // R4: a write beat always pairs an even word with the odd word just above it
  p_bank_pair_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> !wa_even[0] && wa_odd[0] && (wa_odd[WADDR_W-1:1] == wa_even[WADDR_W-1:1]));
endmodule

// File: rtl/qb4_sram_seq.sv
module qb4_sram_seq
  import qb4_pkg::*;
#(
  parameter  int ADDR_W  = 6,
  parameter  int DATA_W  = 16,
  localparam int WADDR_W = ADDR_W + $clog2(BURST_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_sel_n,
  input  logic               wr_sel_n,
  input  logic [ADDR_W-1:0]  ext_addr,
  input  logic [DATA_W-1:0]  wr_data_even,
  input  logic [DATA_W-1:0]  wr_data_odd,
  output logic               wr_ready,
  output logic [WADDR_W-1:0] wr_addr_even,
  output logic [WADDR_W-1:0] wr_addr_odd,
  output logic               rd_valid,
  output logic [WADDR_W-1:0] rd_addr_even,
  output logic [WADDR_W-1:0] rd_addr_odd,
  output logic [DATA_W-1:0]  rd_data_even,
  output logic [DATA_W-1:0]  rd_data_odd
);
  logic rd_start, rd_init;
  logic wr_start, wr_init;

  qb4_burst_fsm #(.ADDR_W(ADDR_W)) u_rd_fsm (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (rd_sel_n),
    .hold_off  (1'b0),
    .base_in   (ext_addr),
    .start     (rd_start),
    .active    (rd_valid),
    .init      (rd_init),
    .word_even (rd_addr_even),
    .word_odd  (rd_addr_odd)
  );

  // a read start on this edge blocks any write start
  qb4_burst_fsm #(.ADDR_W(ADDR_W)) u_wr_fsm (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (wr_sel_n),
    .hold_off  (rd_start),
    .base_in   (ext_addr),
    .start     (wr_start),
    .active    (wr_ready),
    .init      (wr_init),
    .word_even (wr_addr_even),
    .word_odd  (wr_addr_odd)
  );

  qb4_word_array #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_ready),
    .wa_even (wr_addr_even),
    .wa_odd  (wr_addr_odd),
    .wd_even (wr_data_even),
    .wd_odd  (wr_data_odd),
    .ra_even (rd_addr_even),
    .ra_odd  (rd_addr_odd),
    .rd_even (rd_data_even),
    .rd_odd  (rd_data_odd)
  );

  // R1: with no read request an idle read port stays idle
  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && rd_sel_n) |=> !rd_valid);
  // R2: the first-beat flag coincides with offset zero
  p_rd_first_r2: assert property (@(posedge clk) disable iff (rst)
    rd_init |-> rd_valid && (rd_addr_even[1:0] == 2'd0));
  p_wr_first_r2: assert property (@(posedge clk) disable iff (rst)
    wr_init |-> wr_ready && (wr_addr_even[1:0] == 2'd0));
  // R7: concurrent bursts stay on opposite beats
  p_phase_apart_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && wr_ready) |-> (rd_addr_even[1:0] != wr_addr_even[1:0]));
  // R8: never two starts on one edge; an idle write loses to a read
  p_one_start_r8: assert property (@(posedge clk) disable iff (rst)
    !(rd_start && wr_start));
  p_read_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !wr_ready) |=> !wr_ready);
endmodule

// File: tb/qb4_sram_seq_tb_top.sv
module qb4_sram_seq_tb_top;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int WAW = AW + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst, rs_n, ws_n;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wde, wdo;
  logic           wr_ready, rd_valid;
  logic [WAW-1:0] wr_addr_even, wr_addr_odd, rd_addr_even, rd_addr_odd;
  logic [DW-1:0]  rd_data_even, rd_data_odd;

  qb4_sram_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .rd_sel_n(rs_n), .wr_sel_n(ws_n), .ext_addr(addr),
    .wr_data_even(wde), .wr_data_odd(wdo), .wr_ready(wr_ready),
    .wr_addr_even(wr_addr_even), .wr_addr_odd(wr_addr_odd), .rd_valid(rd_valid),
    .rd_addr_even(rd_addr_even), .rd_addr_odd(rd_addr_odd),
    .rd_data_even(rd_data_even), .rd_data_odd(rd_data_odd)
  );

  typedef struct {
    logic [WAW-1:0] ev;
    logic [WAW-1:0] od;
    string          req;
  } exp_t;

  exp_t           rdq[$];
  exp_t           wrq[$];
  exp_t           rx, wx;
  logic [DW-1:0]  shadow [1 << WAW];
  int             checks = 0;
  int             fails  = 0;
  int             cyc    = 0;
  bit             done   = 1'b0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_burst(bit is_rd, logic [AW-1:0] b, string req);
    exp_t x0, x1;
    x0.ev = {b, 2'd0}; x0.od = {b, 2'd1}; x0.req = req;
    x1.ev = {b, 2'd2}; x1.od = {b, 2'd3}; x1.req = req;
    if (is_rd) begin rdq.push_back(x0); rdq.push_back(x1); end
    else       begin wrq.push_back(x0); wrq.push_back(x1); end
  endtask

  // drives the inputs sampled at the next rising edge
  task automatic tick(bit r, bit w, logic [AW-1:0] a);
    @(negedge clk); #1;
    cyc++;
    rs_n = r; ws_n = w; addr = a;
    wde = DW'(16'h1357 * cyc);
    wdo = ~wde ^ DW'(cyc);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: one expected entry per strobe; reads compared before this cycle's write lands
  always begin
    @(negedge clk); #2;
    if (!rst) begin
      if (rd_valid) begin
        if (rdq.size() == 0) check(1'b0, "R1", "unexpected rd_valid", 1, 0);
        else begin
          rx = rdq.pop_front();
          check(rd_addr_even == rx.ev, rx.req, "rd_addr_even", rd_addr_even, rx.ev);
          check(rd_addr_odd  == rx.od, rx.req, "rd_addr_odd",  rd_addr_odd,  rx.od);
          check(rd_data_even === shadow[rx.ev], "R9", "rd_data_even", rd_data_even, shadow[rx.ev]);
          check(rd_data_odd  === shadow[rx.od], "R9", "rd_data_odd",  rd_data_odd,  shadow[rx.od]);
        end
      end
      if (wr_ready) begin
        if (wrq.size() == 0) check(1'b0, "R8", "unexpected wr_ready", 1, 0);
        else begin
          wx = wrq.pop_front();
          check(wr_addr_even == wx.ev, wx.req, "wr_addr_even", wr_addr_even, wx.ev);
          check(wr_addr_odd  == wx.od, wx.req, "wr_addr_odd",  wr_addr_odd,  wx.od);
          shadow[wx.ev] = wde;
          shadow[wx.od] = wdo;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst = 1'b1; rs_n = 1'b1; ws_n = 1'b1; addr = '0; wde = '0; wdo = '0;
    repeat (3) @(negedge clk);
    #2;
    check(!rd_valid, "R1", "rd_valid in reset", rd_valid, 0);
    check(!wr_ready, "R1", "wr_ready in reset", wr_ready, 0);
    @(negedge clk); #1 rst = 1'b0;
    repeat (3) tick(1, 1, '0);

    // R2 R3 R5: sixteen back-to-back write bursts fill bases 0..15
    for (int b = 0; b < 16; b++) begin
      tick(1, 0, AW'(b)); push_burst(0, AW'(b), "R5");
      tick(1, 1, '0);
    end
    tick(1, 1, '0);
    // R4: top base, no wrap
    tick(1, 0, AW'(63)); push_burst(0, AW'(63), "R4");
    tick(1, 1, '0); tick(1, 1, '0);

    // R2 R3 R5 R9: back-to-back reads of bases 0..3
    for (int b = 0; b < 4; b++) begin
      tick(0, 1, AW'(b)); push_burst(1, AW'(b), "R3");
      tick(1, 1, '0);
    end
    tick(1, 1, '0);
    tick(0, 1, AW'(63)); push_burst(1, AW'(63), "R4");
    tick(1, 1, '0); tick(1, 1, '0);

    // R6: requests during the first beat are ignored
    tick(1, 0, AW'(20)); push_burst(0, AW'(20), "R6");
    tick(1, 0, AW'(33));
    tick(1, 1, '0); tick(1, 1, '0);
    tick(0, 1, AW'(20)); push_burst(1, AW'(20), "R6");
    tick(0, 1, AW'(40));
    tick(1, 1, '0); tick(1, 1, '0);

    // R8: simultaneous requests from idle and at a read reload; write dropped
    tick(0, 0, AW'(4)); push_burst(1, AW'(4), "R8");
    tick(1, 1, '0);
    tick(0, 0, AW'(5)); push_burst(1, AW'(5), "R8");
    tick(1, 1, '0); tick(1, 1, '0); tick(1, 1, '0);

    // R7: overlapping write and read bursts
    tick(1, 0, AW'(24)); push_burst(0, AW'(24), "R7");
    tick(0, 1, AW'(6));  push_burst(1, AW'(6),  "R7");
    tick(1, 1, '0); tick(1, 1, '0);
    tick(0, 1, AW'(24)); push_burst(1, AW'(24), "R9");
    tick(1, 1, '0); tick(1, 1, '0);

    repeat (4) tick(1, 1, '0);
    @(negedge clk); #3;
    check(rdq.size() == 0, "R3", "read beats outstanding", rdq.size(), 0);
    check(wrq.size() == 0, "R3", "write beats outstanding", wrq.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule